// File: doc/BRIEF.md
# Sprite Overlay Engine

This engine lays up to sixteen 16x16 sprites over a 640x480 framebuffer image. When the scan enters vertical blanking it walks a descriptor table in a word-addressed 16-bit memory, copying each sprite's bitmap address, position, transparent colour and all 64 bitmap words into private storage. It then needs no further memory traffic until the next blanking interval.

During active video every sprite tests the current pixel coordinate against its own box in parallel. Each sprite that covers the pixel also looks up its stored colour. Where an opaque sprite pixel exists it replaces the framebuffer colour. Where none exists the framebuffer colour passes through. Outside the visible area the colour outputs are held dark. The host scan logic supplies the coordinates, the visible flag and the framebuffer colour, and serves the engine's read requests from memory.

Top module: `sprite_engine`

## Requirements
- R1: After reset, mem_rd, fetch_done and all three colour outputs are 0, and every sprite is disabled, so a visible pixel shows the framebuffer colour.
- R2: A fetch starts on the first cycle in which pix_x >= 640 and pix_y == 479 both hold. On the next cycle mem_rd is 1 and mem_addr is word 28, which is byte 56 shifted right by one.
- R3: For sprite i, counting from 0, the engine presents one address per cycle. These are word 28+4i (bitmap byte address), then 29+4i (x), 30+4i (y) and 31+4i (transparent colour), then the 64 words starting at the bitmap byte address shifted right by one. The data for each address is captured one cycle after that address is driven.
- R4: One cycle after the last bitmap word of sprite 15 is driven, mem_rd drops to 0, mem_addr shows the video memory start (word 96 by default), and fetch_done goes to 1. fetch_done stays at 1 until the next fetch starts and is 0 while a fetch is running.
- R5: A fetch starts only on a rising edge of the start condition. Holding the condition starts nothing further, and a new rising edge while a fetch is running is ignored.
- R6: Bitmap word k holds line k/4. Its bits [15:12] are the leftmost of its four pixels. Each 4-bit pixel is laid out as bit 3 unused, bit 2 red, bit 1 green, bit 0 blue.
- R7: A sprite covers a pixel only when its bitmap address is nonzero, x is in [sx, sx+16) and y is in [sy, sy+16).
- R8: A covering sprite's pixel is opaque when its bits [2:0] differ from bits [2:0] of the transparent colour word. Otherwise the framebuffer colour shows through. Bit 3 takes no part in the comparison.
- R9: When several covering sprites are opaque at one pixel, the lowest-numbered one supplies the colour.
- R10: On a cycle with pix_valid at 0, the colour outputs of the following cycle are all 0.
- R11: The colour outputs are registered. Values reflect the inputs of the previous cycle, with red on vid_r, green on vid_g and blue on vid_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_x | input | 16 | Current horizontal pixel coordinate |
| pix_y | input | 16 | Current vertical pixel coordinate |
| pix_valid | input | 1 | High inside the visible area |
| fb_rgb | input | 3 | Framebuffer colour of the current pixel, red in bit 2 |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_addr | output | 16 | Word read address |
| mem_rd | output | 1 | Read strobe |
| vid_r | output | 1 | Red output |
| vid_g | output | 1 | Green output |
| vid_b | output | 1 | Blue output |
| fetch_done | output | 1 | Sprite tables loaded for this frame |

## Verification
Two things can meet in one cycle: a fresh blanking-entry edge can arrive while a table walk is still in progress, and capture writes into a sprite's storage can occur while the output path is running. The bench drops the start condition partway through a walk and then raises it again. The address stream is required to continue word for word with no restart, and the colour outputs are required to stay dark throughout. A second walk over an edited table then confirms that moved and disabled sprites are picked up, which shows that captures land in the right slots.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [2:0] {
    FS_IDLE, FS_BMP, FS_X, FS_Y, FS_TC, FS_PIX
  } fetch_st_e;

  // word address of field fld of descriptor idx
  function automatic int unsigned desc_word(input int unsigned base,
                                            input int unsigned idx,
                                            input int unsigned fld);
    return base + idx * 4 + fld;
  endfunction

  // half-open range test [pos, pos+dim)
  function automatic logic in_box(input int unsigned p,
                                  input int unsigned pos,
                                  input int unsigned dim);
    return (p >= pos) && (p < pos + dim);
  endfunction

  // bit index of the top bit of pixel col in a line of width lw
  function automatic int unsigned nib_top(input int unsigned lw,
                                          input int unsigned col);
    return lw - 1 - 4 * col;
  endfunction

endpackage

// File: rtl/spr_fetch.sv
module spr_fetch
  import spr_pkg::*;
#(
  parameter int NUM       = 16,
  parameter int DIM       = 16,
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int H_ACT     = 640,
  parameter int V_LAST    = 479,
  parameter int DESC_BASE = 28,
  parameter int VMEM_BASE = 96,
  localparam int WORDS    = DIM * DIM * 4 / DW,
  localparam int IW       = $clog2(NUM),
  localparam int KW       = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [DW-2:0] base_w,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          fetch_done,
  output logic          busy,
  output logic          cap_bmp,
  output logic          cap_x,
  output logic          cap_y,
  output logic          cap_tc,
  output logic          cap_pix,
  output logic [IW-1:0] cap_spr,
  output logic [KW-1:0] cap_word
);

  localparam logic [CW-1:0] H_ACT_C  = CW'(H_ACT);
  localparam logic [CW-1:0] V_LAST_C = CW'(V_LAST);

  fetch_st_e     st;
  logic [AW-1:0] addr_q;
  logic          rd_q, done_q, cond_q;
  logic [IW-1:0] spr_q;
  logic [KW-1:0] word_q;
  logic          cond, start;

  assign cond  = (pix_x >= H_ACT_C) && (pix_y == V_LAST_C);
  assign start = cond && !cond_q && (st == FS_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= FS_IDLE;
      addr_q <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      cond_q <= 1'b0;
      spr_q  <= '0;
      word_q <= '0;
    end else begin
      cond_q <= cond;
      unique case (st)
        FS_IDLE: if (start) begin
          st     <= FS_BMP;
          addr_q <= AW'(desc_word(DESC_BASE, 0, 0));
          rd_q   <= 1'b1;
          done_q <= 1'b0;
          spr_q  <= '0;
        end
        FS_BMP: begin
          addr_q <= AW'(desc_word(DESC_BASE, 32'(spr_q), 1));
          st     <= FS_X;
        end
        FS_X: begin
          addr_q <= AW'(desc_word(DESC_BASE, 32'(spr_q), 2));
          st     <= FS_Y;
        end
        FS_Y: begin
          addr_q <= AW'(desc_word(DESC_BASE, 32'(spr_q), 3));
          st     <= FS_TC;
        end
        FS_TC: begin
          addr_q <= AW'(base_w);
          word_q <= '0;
          st     <= FS_PIX;
        end
        FS_PIX: begin
          if (word_q == KW'(WORDS - 1)) begin
            if (spr_q == IW'(NUM - 1)) begin
              st     <= FS_IDLE;
              rd_q   <= 1'b0;
              addr_q <= AW'(VMEM_BASE);
              done_q <= 1'b1;
            end else begin
              spr_q  <= spr_q + 1'b1;
              addr_q <= AW'(desc_word(DESC_BASE, 32'(spr_q) + 1, 0));
              st     <= FS_BMP;
            end
          end else begin
            word_q <= word_q + 1'b1;
            addr_q <= AW'(32'(base_w) + 32'(word_q) + 1);
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign mem_addr   = addr_q;
  assign mem_rd     = rd_q;
  assign fetch_done = done_q;
  assign busy       = (st != FS_IDLE);
  assign cap_bmp    = (st == FS_BMP);
  assign cap_x      = (st == FS_X);
  assign cap_y      = (st == FS_Y);
  assign cap_tc     = (st == FS_TC);
  assign cap_pix    = (st == FS_PIX);
  assign cap_spr    = spr_q;
  assign cap_word   = word_q;

endmodule

// File: rtl/spr_bank.sv
module spr_bank
  import spr_pkg::*;
#(
  parameter int NUM    = 16,
  parameter int DIM    = 16,
  parameter int DW     = 16,
  parameter int CW     = 16,
  localparam int LW    = DIM * 4,
  localparam int WPL   = LW / DW,
  localparam int WORDS = DIM * WPL,
  localparam int IW    = $clog2(NUM),
  localparam int KW    = $clog2(WORDS),
  localparam int SW    = $clog2(WPL),
  localparam int RW    = $clog2(DIM),
  localparam int MW    = $clog2(LW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_bmp,
  input  logic                cap_x,
  input  logic                cap_y,
  input  logic                cap_tc,
  input  logic                cap_pix,
  input  logic [IW-1:0]       cap_spr,
  input  logic [KW-1:0]       cap_word,
  input  logic [DW-1:0]       wdata,
  input  logic [CW-1:0]       pix_x,
  input  logic [CW-1:0]       pix_y,
  output logic [DW-2:0]       base_w,
  output logic [NUM-1:0]      hit,
  output logic [NUM-1:0]      opq,
  output logic [NUM-1:0][2:0] pix_rgb
);

  logic [NUM-1:0][DW-1:0] bmp_all;

  for (genvar g = 0; g < NUM; g++) begin : g_spr
    logic [DW-1:0] bmp_r;
    logic [CW-1:0] sx_r, sy_r;
    logic [2:0]    tc_r;
    logic [LW-1:0] lines [DIM];
    logic [RW-1:0] row_i, col_i;
    logic [MW-1:0] msb_i;
    logic [2:0]    rgb_w;
    logic          sel_w;

    assign sel_w = (cap_spr == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bmp_r <= '0;
        sx_r  <= '0;
        sy_r  <= '0;
        tc_r  <= '0;
      end else if (sel_w) begin
        if (cap_bmp) bmp_r <= wdata;
        if (cap_x)   sx_r  <= CW'(wdata);
        if (cap_y)   sy_r  <= CW'(wdata);
        if (cap_tc)  tc_r  <= wdata[2:0];
      end
    end

    always_ff @(posedge clk) begin
      if (cap_pix && sel_w)
        lines[cap_word[KW-1:SW]][LW - 1 - DW * int'(cap_word[SW-1:0]) -: DW] <= wdata;
    end

    assign row_i = RW'(pix_y - sy_r);
    assign col_i = RW'(pix_x - sx_r);
    assign msb_i = MW'(nib_top(LW, 32'(col_i)) - 1);
    assign rgb_w = lines[row_i][msb_i -: 3];

    assign hit[g] = (bmp_r != '0) &&
                    in_box(32'(pix_x), 32'(sx_r), DIM) &&
                    in_box(32'(pix_y), 32'(sy_r), DIM);
    assign opq[g]     = (rgb_w != tc_r);
    assign pix_rgb[g] = rgb_w;
    assign bmp_all[g] = bmp_r;
  end

  assign base_w = bmp_all[cap_spr][DW-1:1];

endmodule

// File: rtl/spr_mix.sv
module spr_mix #(
  parameter int NUM = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_valid,
  input  logic [2:0]          fb_rgb,
  input  logic [NUM-1:0]      hit,
  input  logic [NUM-1:0]      opq,
  input  logic [NUM-1:0][2:0] pix_rgb,
  output logic                any_opq,
  output logic                vid_r,
  output logic                vid_g,
  output logic                vid_b
);

  logic [2:0] sel_rgb, out_q;

  // walk downward so the lowest index is written last and wins
  always_comb begin
    sel_rgb = fb_rgb;
    any_opq = 1'b0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (hit[i] && opq[i]) begin
        sel_rgb = pix_rgb[i];
        any_opq = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 3'b000;
    else        out_q <= pix_valid ? sel_rgb : 3'b000;
  end

  assign vid_r = out_q[2];
  assign vid_g = out_q[1];
  assign vid_b = out_q[0];

endmodule

// File: rtl/sprite_engine.sv
module sprite_engine #(
  parameter int NUM_SPR   = 16,
  parameter int SPR_DIM   = 16,
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int H_ACT     = 640,
  parameter int V_LAST    = 479,
  parameter int DESC_BASE = 28,
  parameter int VMEM_BASE = 96,
  localparam int WORDS    = SPR_DIM * SPR_DIM * 4 / DW,
  localparam int IW       = $clog2(NUM_SPR),
  localparam int KW       = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic          pix_valid,
  input  logic [2:0]    fb_rgb,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          vid_r,
  output logic          vid_g,
  output logic          vid_b,
  output logic          fetch_done
);

  logic                    busy, any_opq;
  logic                    cap_bmp, cap_x, cap_y, cap_tc, cap_pix;
  logic [IW-1:0]           cap_spr;
  logic [KW-1:0]           cap_word;
  logic [DW-2:0]           base_w;
  logic [NUM_SPR-1:0]      hit, opq;
  logic [NUM_SPR-1:0][2:0] pix_rgb;

  spr_fetch #(
    .NUM(NUM_SPR), .DIM(SPR_DIM), .AW(AW), .DW(DW), .CW(CW),
    .H_ACT(H_ACT), .V_LAST(V_LAST), .DESC_BASE(DESC_BASE), .VMEM_BASE(VMEM_BASE)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .base_w(base_w),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .fetch_done(fetch_done), .busy(busy),
    .cap_bmp(cap_bmp), .cap_x(cap_x), .cap_y(cap_y), .cap_tc(cap_tc),
    .cap_pix(cap_pix), .cap_spr(cap_spr), .cap_word(cap_word)
  );

  spr_bank #(
    .NUM(NUM_SPR), .DIM(SPR_DIM), .DW(DW), .CW(CW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_bmp(cap_bmp), .cap_x(cap_x), .cap_y(cap_y),
    .cap_tc(cap_tc), .cap_pix(cap_pix), .cap_spr(cap_spr), .cap_word(cap_word),
    .wdata(mem_rdata), .pix_x(pix_x), .pix_y(pix_y), .base_w(base_w),
    .hit(hit), .opq(opq), .pix_rgb(pix_rgb)
  );

  spr_mix #(
    .NUM(NUM_SPR)
  ) u_mix (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .fb_rgb(fb_rgb),
    .hit(hit), .opq(opq), .pix_rgb(pix_rgb), .any_opq(any_opq),
    .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b)
  );

endmodule

// File: rtl/sprite_engine_chk.sv
module sprite_engine_chk #(
  parameter int AW        = 16,
  parameter int DESC_BASE = 28,
  parameter int VMEM_BASE = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic [2:0]    fb_rgb,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          vid_r,
  input logic          vid_g,
  input logic          vid_b,
  input logic          fetch_done,
  input logic          busy,
  input logic          any_opq,
  input logic          cap_bmp,
  input logic          cap_x,
  input logic          cap_y,
  input logic          cap_tc,
  input logic          cap_pix
);

  p_dark_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ({vid_r, vid_g, vid_b} == 3'b000));

  p_first_desc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> (mem_addr == AW'(DESC_BASE)));

  p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> (!mem_rd && !busy));

  p_done_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_done) |-> (mem_addr == AW'(VMEM_BASE)));

  p_one_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_bmp, cap_x, cap_y, cap_tc, cap_pix}));

  p_read_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mem_rd);

  p_fb_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !any_opq) |=> ({vid_r, vid_g, vid_b} == $past(fb_rgb)));

endmodule

bind sprite_engine sprite_engine_chk #(
  .AW(AW), .DESC_BASE(DESC_BASE), .VMEM_BASE(VMEM_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .fb_rgb(fb_rgb),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .vid_r(vid_r), .vid_g(vid_g),
  .vid_b(vid_b), .fetch_done(fetch_done), .busy(busy), .any_opq(any_opq),
  .cap_bmp(cap_bmp), .cap_x(cap_x), .cap_y(cap_y), .cap_tc(cap_tc),
  .cap_pix(cap_pix)
);

// File: tb/sprite_engine_tb.sv
module sprite_engine_tb;

  localparam int PERIOD = 4;
  localparam int NSPR   = 16;
  localparam int VMEM   = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pix_x = '0, pix_y = '0;
  logic        pix_valid = 1'b0;
  logic [2:0]  fb_rgb = '0;
  logic [15:0] mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, vid_r, vid_g, vid_b, fetch_done;
  logic [15:0] mem [0:4095];

  always #(PERIOD / 2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:0]];

  sprite_engine u_dut (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .pix_valid(pix_valid), .fb_rgb(fb_rgb), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .vid_r(vid_r), .vid_g(vid_g),
    .vid_b(vid_b), .fetch_done(fetch_done)
  );

  int    n_chk = 0, n_bad = 0;
  int    exp_rgb = 0;
  bit    exp_pend = 0;
  string exp_req = "";
  bit    finished = 0;

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp_v);
    end
  endtask

  function automatic int rgb_now();
    return int'({vid_r, vid_g, vid_b});
  endfunction

  // behavioural view of the overlay, read straight from the table in memory
  function automatic int model(input int x, input int y, input int fb);
    for (int i = 0; i < NSPR; i++) begin
      int b  = int'(mem[28 + 4 * i]);
      int sx = int'(mem[29 + 4 * i]);
      int sy = int'(mem[30 + 4 * i]);
      int tc = int'(mem[31 + 4 * i]);
      if (b != 0 && x >= sx && x < sx + 16 && y >= sy && y < sy + 16) begin
        int w   = int'(mem[b / 2 + (y - sy) * 4 + (x - sx) / 4]);
        int nib = (w >> (12 - 4 * ((x - sx) % 4))) & 15;
        if ((nib & 7) != (tc & 7)) return nib & 7;
      end
    end
    return fb;
  endfunction

  task automatic step(input int x, input int y, input bit v, input bit use_model,
                      input string req);
    int fb;
    @(negedge clk);
    if (exp_pend) chk(exp_req, rgb_now(), exp_rgb);
    fb        = (x + 3 * y) & 7;
    pix_x     = 16'(x);
    pix_y     = 16'(y);
    pix_valid = v;
    fb_rgb    = 3'(fb);
    exp_rgb   = !v ? 0 : (use_model ? model(x, y, fb) : fb);
    exp_req   = req;
    exp_pend  = 1;
  endtask

  task automatic sweep(input int x0, input int x1, input int y0, input int y1,
                       input bit use_model, input string req);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        step(x, y, 1'b1, use_model, req);
  endtask

  task automatic do_fetch(input bit retrig);
    int q[$];
    int cyc = 0;
    for (int i = 0; i < NSPR; i++) begin
      for (int f = 0; f < 4; f++) q.push_back(28 + 4 * i + f);
      for (int k = 0; k < 64; k++) q.push_back((int'(mem[28 + 4 * i]) / 2 + k) & 16'hFFFF);
    end
    @(negedge clk);
    if (exp_pend) chk(exp_req, rgb_now(), exp_rgb);
    exp_pend  = 0;
    pix_valid = 1'b0;
    pix_x     = 16'd640;
    pix_y     = 16'd479;
    while (q.size() > 0) begin
      int e;
      @(negedge clk);
      e = q.pop_front();
      chk(cyc == 0 ? "R2" : ((retrig && cyc > 150) ? "R5" : "R3"),
          (int'(mem_rd) << 16) | int'(mem_addr), (1 << 16) | e);
      chk("R10", rgb_now(), 0);
      chk("R4", int'(fetch_done), 0);
      cyc++;
      if (retrig) begin
        if (cyc == 100) pix_y = 16'd0;
        if (cyc == 150) pix_y = 16'd479;
        if (cyc == 200) begin pix_y = 16'd0; pix_x = 16'd0; end
      end
    end
    @(negedge clk);
    chk("R4", int'(mem_rd), 0);
    chk("R4", int'(mem_addr), VMEM);
    chk("R4", int'(fetch_done), 1);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk("R5", int'(mem_rd), 0);
      chk("R4", int'(fetch_done), 1);
    end
    pix_x = 16'd0;
    pix_y = 16'd0;
  endtask

  task automatic put_spr(input int i, input int bmp, input int x, input int y, input int tc);
    mem[28 + 4 * i] = 16'(bmp);
    mem[29 + 4 * i] = 16'(x);
    mem[30 + 4 * i] = 16'(y);
    mem[31 + 4 * i] = 16'(tc);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = '0;
    // bitmaps: varied words, some nibbles forced to zero
    for (int s = 0; s < 6; s++)
      for (int k = 0; k < 64; k++) begin
        int w = ((k * 4957 + s * 911) ^ 16'hA5C3) & 16'hFFFF;
        if (k % 3 == 0) w = w & 16'hF0FF;
        if (k % 5 == 1) w = w & 16'hFF0F;
        mem[16'h200 + s * 16'h80 + k] = 16'(w);
      end
    put_spr(0, 16'h400, 100, 100, 0);
    put_spr(1, 16'h500, 108, 104, 5);
    put_spr(2, 0, 100, 100, 0);
    put_spr(3, 16'h600, 0, 0, 8);
    put_spr(4, 16'h700, 630, 470, 3);
    put_spr(5, 16'h800, 112, 96, 1);

    repeat (4) @(negedge clk);
    chk("R1", int'(mem_rd), 0);
    chk("R1", int'(fetch_done), 0);
    chk("R1", rgb_now(), 0);
    rst_n = 1'b1;

    sweep(98, 110, 98, 106, 1'b0, "R1");
    chk("R1", int'(mem_rd), 0);

    do_fetch(1'b1);
    sweep(95, 130, 93, 122, 1'b1, "R9");
    sweep(0, 19, 0, 19, 1'b1, "R8");
    sweep(620, 639, 462, 479, 1'b1, "R7");
    for (int n = 0; n < 8; n++) step(104 + n, 104, 1'b0, 1'b1, "R10");

    put_spr(0, 16'h400, 200, 150, 0);
    put_spr(1, 0, 108, 104, 5);
    do_fetch(1'b0);
    sweep(195, 220, 145, 170, 1'b1, "R6");
    sweep(105, 125, 100, 120, 1'b1, "R11");
    step(0, 0, 1'b0, 1'b1, "R10");
    step(0, 0, 1'b0, 1'b1, "R10");
    finish_run();
  end

endmodule